// File: doc/BRIEF.md
# CAN Receive Buffer Controller

This block governs a single CAN receive message buffer. A protocol engine hands it one decoded frame at a time, as a one-cycle strobe with these qualifiers:
- whether the identifier is extended;
- whether the frame is a remote transmission request;
- whether the frame carried an error;
- whether an acceptance filter matched, and the 5-bit index of that filter.

The block applies an acceptance policy that depends on the operating mode and on software-programmed receive-mode bits. It then either issues a load strobe to the payload storage, or drops the frame. When the buffer is already occupied, it drops the frame and raises an overflow pulse. When it loads a frame, it sets a full flag, captures status (remote-request flag and filter index) and raises a receive interrupt.

Software sees one 8-bit control/status byte through a simple read/write port. Its layout changes with the operating mode. Software releases the buffer by writing 0 to the full bit. While the buffer stays full, the interrupt flag cannot be cleared.

Top module: `can_rxbuf_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, the interrupt flag is 0, and no load or overflow pulse is produced.
- R2: A frame strobe that passes the acceptance policy while the full flag (register bit 7) is 0 produces a load pulse in the same cycle and sets the full flag from the next cycle.
- R3: While the full flag is 1, no frame is loaded. A frame that passes the policy in that state produces an overflow pulse in the same cycle and leaves the stored status unchanged.
- R4: The full flag is cleared only by a register write with bit 7 equal to 0. A write with bit 7 equal to 1 leaves it unchanged. If a load and a clearing write occur in the same cycle, the flag ends up set.
- R5: The interrupt flag is set by a load. It stays set while the full flag is 1, even if an interrupt-clear request arrives. It falls after a clear request only once the full flag is 0.
- R6: Operating mode 0 is legacy mode. Its receive-mode field is {bit 6, bit 5}:
  - 11 accepts every frame, including errored frames.
  - 10 accepts error-free, filter-matched frames with an extended identifier.
  - 01 accepts error-free, filter-matched frames with a standard identifier.
  - 00 accepts error-free, filter-matched frames of either identifier type.
- R7: Operating modes 1, 2 and 3 are enhanced modes. When bit 6 is 1, every frame is accepted. When bit 6 is 0, only error-free, filter-matched frames are accepted.
- R8: In legacy mode, the register reads as {full, mode1, mode0, 0, rtr, 0, 0, filter index bit 0}. Writes update bits 6 and 5.
- R9: In enhanced modes, the register reads as {full, mode1, rtr, filter index[4:0]}. Writes update only bit 6, and bits 5..0 ignore writes.
- R10: The RTR flag and the filter index change only on a load, and take that frame's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_mode | input | 2 | 0 legacy, 1..3 enhanced |
| frm_valid | input | 1 | One-cycle strobe: a decoded frame is complete |
| frm_ext | input | 1 | Frame has an extended identifier |
| frm_rtr | input | 1 | Frame is a remote transmission request |
| frm_err | input | 1 | Frame was received with an error |
| flt_match | input | 1 | An acceptance filter matched the frame |
| flt_idx | input | 5 | Index of the matching filter |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| irq_clr | input | 1 | Software request to clear the interrupt flag |
| reg_rdata | output | 8 | Control/status byte |
| load_o | output | 1 | Load strobe to payload storage |
| ovf_o | output | 1 | Overflow pulse: acceptable frame arrived while full |
| irq_o | output | 1 | Receive interrupt flag |

## Verification
Random frames cover every combination of identifier type, error and filter match under all four legacy receive-mode codes and both enhanced settings. These separate each acceptance code from its neighbours, in particular 10 from 01 and 00 from 11.

Random register writes and interrupt clears land while the buffer is both empty and full. This separates a genuine release from an ignored write, and a lasting interrupt clear from one that is refused.

Directed cases hit a load together with a clearing write in the same cycle, a clear request while the buffer is full, and overflow with its status hold. Switching the operating mode on a loaded buffer tells the two register layouts apart.

// File: rtl/can_rxbuf_ctrl.sv
module can_rxbuf_ctrl #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_mode,
  input  logic             frm_valid,
  input  logic             frm_ext,
  input  logic             frm_rtr,
  input  logic             frm_err,
  input  logic             flt_match,
  input  logic [IDX_W-1:0] flt_idx,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  input  logic             irq_clr,
  output logic [7:0]       reg_rdata,
  output logic             load_o,
  output logic             ovf_o,
  output logic             irq_o
);

  logic             full_q, rm1_q, rm0_q, rtr_q, irq_q;
  logic [IDX_W-1:0] idx_q;
  logic             legacy, clean, accept, sw_release, full_d;

  assign legacy = (op_mode == 2'd0);
  assign clean  = !frm_err && flt_match;

  always_comb begin
    if (legacy) begin
      unique case ({rm1_q, rm0_q})
        2'b11:   accept = 1'b1;
        2'b10:   accept = clean && frm_ext;
        2'b01:   accept = clean && !frm_ext;
        default: accept = clean;
      endcase
    end else begin
      accept = rm1_q || clean;
    end
  end

  assign load_o     = frm_valid && accept && !full_q;
  assign ovf_o      = frm_valid && accept && full_q;
  assign sw_release = reg_wr && !reg_wdata[7];
  assign full_d     = load_o || (full_q && !sw_release);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      rm1_q  <= 1'b0;
      rm0_q  <= 1'b0;
      rtr_q  <= 1'b0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      irq_q  <= load_o || full_d || (irq_q && !irq_clr);
      if (reg_wr) begin
        rm1_q <= reg_wdata[6];
        if (legacy) rm0_q <= reg_wdata[5];
      end
      if (load_o) begin
        rtr_q <= frm_rtr;
        idx_q <= flt_idx;
      end
    end
  end

  always_comb begin
    if (legacy)
      reg_rdata = {full_q, rm1_q, rm0_q, 1'b0, rtr_q, 2'b00, idx_q[0]};
    else
      reg_rdata = {full_q, rm1_q, rtr_q, 5'(idx_q)};
  end

  assign irq_o = irq_q;

endmodule

module can_rxbuf_ctrl_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full_q,
  input logic             irq_q,
  input logic             load_o,
  input logic             ovf_o,
  input logic             reg_wr,
  input logic [7:0]       reg_wdata,
  input logic [IDX_W-1:0] idx_q,
  input logic             rtr_q
);
  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> !load_o);
  assert_ovf_only_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> full_q);
  assert_load_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> full_q);
  assert_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !(reg_wr && !reg_wdata[7])) |=> full_q);
  assert_irq_while_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> irq_q);
  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |=> ($stable(idx_q) && $stable(rtr_q)));
endmodule

bind can_rxbuf_ctrl can_rxbuf_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .full_q(full_q), .irq_q(irq_q), .load_o(load_o),
  .ovf_o(ovf_o), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .idx_q(idx_q),
  .rtr_q(rtr_q));

// File: tb/tb_can_rxbuf_ctrl.sv
module tb_can_rxbuf_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] op_mode = '0;
  logic frm_valid = 0, frm_ext = 0, frm_rtr = 0, frm_err = 0, flt_match = 0;
  logic [4:0] flt_idx = '0;
  logic reg_wr = 0, irq_clr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic load_o, ovf_o, irq_o;

  int checks = 0, errors = 0;
  bit m_full, m_rm1, m_rm0, m_rtr, m_irq;
  bit [4:0] m_idx;

  always #5 clk = ~clk;

  can_rxbuf_ctrl dut (.*);

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic bit m_accept();
    bit cl = !frm_err && flt_match;
    if (op_mode == 0)
      case ({m_rm1, m_rm0})
        2'b11: return 1;
        2'b10: return cl && frm_ext;
        2'b01: return cl && !frm_ext;
        default: return cl;
      endcase
    return m_rm1 || cl;
  endfunction

  function automatic bit [7:0] m_read();
    if (op_mode == 0) return {m_full, m_rm1, m_rm0, 1'b0, m_rtr, 2'b00, m_idx[0]};
    return {m_full, m_rm1, m_rtr, m_idx};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, check pulses, clock, update model, check state.
  task automatic step();
    bit ld, fd;
    #1;
    ld = frm_valid && m_accept() && !m_full;
    chk(op_mode == 0 ? "R2/R6 load" : "R2/R7 load", load_o, ld);
    chk("R3 overflow", ovf_o, frm_valid && m_accept() && m_full);
    @(posedge clk);
    fd = ld || (m_full && !(reg_wr && !reg_wdata[7]));
    m_irq = ld || fd || (m_irq && !irq_clr);
    if (reg_wr) begin
      m_rm1 = reg_wdata[6];
      if (op_mode == 0) m_rm0 = reg_wdata[5];
    end
    if (ld) begin m_rtr = frm_rtr; m_idx = flt_idx; end
    m_full = fd;
    #1;
    chk(op_mode == 0 ? "R8/R4/R10 reg" : "R9/R4/R10 reg", reg_rdata, m_read());
    chk("R5 irq", irq_o, m_irq);
    @(negedge clk);
    frm_valid = 0; reg_wr = 0; irq_clr = 0;
  endtask

  task automatic frame(bit e, bit r, bit er, bit m, bit [4:0] ix);
    frm_valid = 1; frm_ext = e; frm_rtr = r; frm_err = er; flt_match = m; flt_idx = ix;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    chk("R1 reset reg", reg_rdata, 8'h00);
    chk("R1 reset irq", irq_o, 0);
    #20 @(negedge clk); rst_n = 1;
    chk("R1 reset reg after release", reg_rdata, 8'h00);
    chk("R1 no pulse", {load_o, ovf_o}, 0);

    // R6 legacy 00: clean frame loads
    frame(1, 1, 0, 1, 5'h13); step();
    chk("R2 full set", reg_rdata[7], 1);
    // R3 overflow, status held
    frame(0, 0, 0, 1, 5'h02); step();
    chk("R10 status held", reg_rdata[3], 1);
    // R5 clear while full refused
    irq_clr = 1; step();
    chk("R5 irq stays while full", irq_o, 1);
    // R4 write with bit7=1 no effect
    reg_wr = 1; reg_wdata = 8'h80; step();
    chk("R4 write 1 keeps full", reg_rdata[7], 1);
    // R4 release
    reg_wr = 1; reg_wdata = 8'h00; step();
    chk("R4 released", reg_rdata[7], 0);
    irq_clr = 1; step();
    chk("R5 irq falls when empty", irq_o, 0);
    // R4 same-cycle load and clear: set wins
    frame(0, 0, 0, 1, 5'h01); reg_wr = 1; reg_wdata = 8'h00; step();
    chk("R4 set wins", reg_rdata[7], 1);
    // R9 enhanced layout
    op_mode = 2'd2; step();
    chk("R9 enhanced idx", reg_rdata[4:0], 5'h01);
    reg_wr = 1; reg_wdata = 8'h00; step();
    // R7 enhanced errored frame rejected then accepted with bit6
    frame(0, 1, 1, 1, 5'h1f); step();
    chk("R7 errored rejected", reg_rdata[7], 0);
    reg_wr = 1; reg_wdata = 8'h40; step();
    frame(0, 1, 1, 0, 5'h1f); step();
    chk("R7 accept all", reg_rdata, 8'hff);

    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) op_mode = 2'($urandom);
      frm_valid = ($urandom % 2) == 0;
      frm_ext = 1'($urandom); frm_rtr = 1'($urandom);
      frm_err = ($urandom % 4) == 0; flt_match = ($urandom % 4) != 0;
      flt_idx = 5'($urandom);
      reg_wr = ($urandom % 7) == 0; reg_wdata = 8'($urandom);
      irq_clr = ($urandom % 5) == 0;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule